// File: doc/BRIEF.md
# Late-Write Synchronous Memory

This block is a single-port synchronous memory whose write data trails its address by one clock. When a write is issued, its address, byte enables and control are registered on that rising edge, and the data word is taken from the data-in bus on the next rising edge. The most recent write waits in a one-deep holding buffer. It is copied into the storage array only when a later write is issued. Because of this, the data-in bus does not have to turn around between a read and a following write, and writes can be issued on every cycle.

Reads are pipelined. The read data is registered one cycle after the read address is registered. A read of the address held in the buffer is made coherent byte by byte: each byte that the pending write enables comes from the buffer, and every other byte comes from the array. An asynchronous output-enable input and an asynchronous sleep input force the data output to zero. Sleep also blocks new accesses during a parameterised entry interval, for as long as it is held, and during a parameterised exit interval after it is released. The array and any pending write survive sleep unchanged.

Top module: `lw_sram`

## Requirements
- R1: After reset the data output is zero, the holding buffer is empty and every array word reads back as zero.
- R2: A write (cs=1, we=1) takes its address and byte enables on the issuing edge and its data word from din on the following edge. Byte i is din[8i+7:8i] and is enabled by be[i].
- R3: When a write is issued, the previous write is committed to the array with only its enabled bytes changed. This holds whether the previous write's data is still arriving on din or already sits in the buffer.
- R4: Writes may be issued on consecutive cycles with no idle cycle between them, and every one of them lands.
- R5: For a read (cs=1, we=0) registered on edge T, the output shows the word from edge T+1 onward and keeps that value until the next read.
- R6: A read whose address matches the buffered write returns the buffer byte for each enabled byte and the array byte for each other byte.
- R7: A read issued on the cycle right after a write, to that write's address, returns that write's new data.
- R8: While oe is low the data output is zero. Raising oe shows the last read word again, unchanged.
- R9: While sleep is high the data output is zero at once, and the array contents are kept.
- R10: Accesses are ignored from the cycle sleep rises, through the entry interval, for as long as sleep stays high, and for SLEEP_EXIT cycles after it falls. After that, accesses are accepted again.
- R11: A write whose data cycle coincides with sleep rising still completes its buffer load and is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Access select, registered |
| we | input | 1 | 1 = write, 0 = read, registered with cs |
| addr | input | AW | Word address, registered |
| be | input | NB | Per-byte write enables, registered with the write |
| din | input | NB*BW | Write data, taken one edge after its write is issued |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous sleep request |
| dout | output | NB*BW | Read data, zero when disabled |

## Verification
The vector table mixes full-word writes, back-to-back writes to different addresses and to the same address, and partial writes with complementary byte masks. These patterns separate data forwarded from the buffer from data committed to the array. Some reads target a word still held in the buffer, some target a word just committed, and some target a word never written. A wrong byte merge, a skipped commit or a lost buffered write therefore each give a distinct wrong word. Directed tests cover output enable, a write whose data cycle meets sleep rising, and writes attempted during sleep and during the exit interval. Reads after wake then show which of those writes took effect.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    SLP_AWAKE  = 2'd0,
    SLP_ENTER  = 2'd1,
    SLP_ASLEEP = 2'd2,
    SLP_EXIT   = 2'd3
  } slp_state_e;

  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/lw_sleep_ctrl.sv
module lw_sleep_ctrl
  import lw_sram_pkg::*;
#(
  parameter int ENTER_CYC = 3,
  parameter int EXIT_CYC  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep,
  output logic       awake,
  output slp_state_e state
);
  localparam int MAXC = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int CW   = cnt_bits(MAXC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SLP_AWAKE;
      cnt   <= '0;
    end else begin
      unique case (state)
        SLP_AWAKE: if (sleep) begin
          state <= SLP_ENTER;
          cnt   <= CW'(ENTER_CYC - 1);
        end
        SLP_ENTER: if (cnt == '0) state <= SLP_ASLEEP;
                   else           cnt   <= cnt - 1'b1;
        SLP_ASLEEP: if (!sleep) begin
          state <= SLP_EXIT;
          cnt   <= CW'(EXIT_CYC - 1);
        end
        SLP_EXIT: if (cnt == '0) state <= SLP_AWAKE;
                  else           cnt   <= cnt - 1'b1;
        default: state <= SLP_AWAKE;
      endcase
    end
  end

  assign awake = (state == SLP_AWAKE);
endmodule

// File: rtl/lw_write_buffer.sv
module lw_write_buffer #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_issue,
  input  logic [AW-1:0]    addr,
  input  logic [NB-1:0]    be,
  input  logic [NB*BW-1:0] din,
  output logic             pend_vld,
  output logic             buf_vld,
  output logic [AW-1:0]    buf_addr,
  output logic [NB-1:0]    buf_be,
  output logic [NB*BW-1:0] buf_data,
  output logic             commit_en,
  output logic [AW-1:0]    commit_addr,
  output logic [NB-1:0]    commit_be,
  output logic [NB*BW-1:0] commit_data
);
  logic [AW-1:0] pend_addr;
  logic [NB-1:0] pend_be;

  // stage 1: control captured on the issuing edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_be   <= '0;
    end else begin
      pend_vld <= wr_issue;
      if (wr_issue) begin
        pend_addr <= addr;
        pend_be   <= be;
      end
    end
  end

  // stage 2: data joins the control one edge later
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_vld  <= 1'b0;
      buf_addr <= '0;
      buf_be   <= '0;
      buf_data <= '0;
    end else if (pend_vld) begin
      buf_vld  <= 1'b1;
      buf_addr <= pend_addr;
      buf_be   <= pend_be;
      buf_data <= din;
    end
  end

  // the previous write retires when a new one is issued
  always_comb begin
    commit_en   = wr_issue && (pend_vld || buf_vld);
    commit_addr = pend_vld ? pend_addr : buf_addr;
    commit_be   = pend_vld ? pend_be   : buf_be;
    commit_data = pend_vld ? din       : buf_data;
  end
endmodule

// File: rtl/lw_array.sv
module lw_array #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [NB-1:0]    wbe,
  input  logic [NB*BW-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [NB*BW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [NB*BW-1:0] mem [DEPTH];

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i][b*BW +: BW] <= '0;
      end else if (we && wbe[b]) begin
        mem[waddr][b*BW +: BW] <= wdata[b*BW +: BW];
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int AW          = 6,
  parameter int NB          = 4,
  parameter int BW          = 8,
  parameter int SLEEP_ENTER = 3,
  parameter int SLEEP_EXIT  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [NB-1:0]    be,
  input  logic [NB*BW-1:0] din,
  input  logic             oe,
  input  logic             sleep,
  output logic [NB*BW-1:0] dout
);
  localparam int DW = NB * BW;

  function automatic logic [DW-1:0] merge_bytes(
    input logic [DW-1:0] newer,
    input logic [DW-1:0] older,
    input logic [NB-1:0] pick
  );
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++)
      r[b*BW +: BW] = pick[b] ? newer[b*BW +: BW] : older[b*BW +: BW];
    return r;
  endfunction

  // named events for the checker
  logic          awake, acc_ok, wr_issue, rd_issue;
  slp_state_e    slp_state;
  logic          pend_vld, buf_vld, commit_en;
  logic [AW-1:0] buf_addr, commit_addr;
  logic [NB-1:0] buf_be, commit_be;
  logic [DW-1:0] buf_data, commit_data, arr_rdata, rd_word, dout_q;
  logic          rd_q, buf_hit;
  logic [AW-1:0] rd_addr_q;

  lw_sleep_ctrl #(.ENTER_CYC(SLEEP_ENTER), .EXIT_CYC(SLEEP_EXIT)) u_slp (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .awake(awake), .state(slp_state)
  );

  assign acc_ok   = cs && awake && !sleep;
  assign wr_issue = acc_ok && we;
  assign rd_issue = acc_ok && !we;

  lw_write_buffer #(.AW(AW), .NB(NB), .BW(BW)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .wr_issue(wr_issue), .addr(addr), .be(be), .din(din),
    .pend_vld(pend_vld), .buf_vld(buf_vld), .buf_addr(buf_addr), .buf_be(buf_be),
    .buf_data(buf_data), .commit_en(commit_en), .commit_addr(commit_addr),
    .commit_be(commit_be), .commit_data(commit_data)
  );

  lw_array #(.AW(AW), .NB(NB), .BW(BW)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(commit_en), .waddr(commit_addr), .wbe(commit_be),
    .wdata(commit_data), .raddr(rd_addr_q), .rdata(arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_q <= rd_issue;
      if (rd_issue) rd_addr_q <= addr;
    end
  end

  assign buf_hit = buf_vld && (buf_addr == rd_addr_q);
  assign rd_word = merge_bytes(buf_data, arr_rdata, buf_hit ? buf_be : '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    dout_q <= '0;
    else if (rd_q) dout_q <= rd_word;
  end

  assign dout = (oe && !sleep) ? dout_q : '0;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk
  import lw_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep,
  input logic [AW-1:0]    addr,
  input logic [NB-1:0]    be,
  input logic [NB*BW-1:0] din,
  input logic             wr_issue,
  input logic             rd_issue,
  input logic             rd_q,
  input logic             pend_vld,
  input logic             buf_vld,
  input logic [AW-1:0]    buf_addr,
  input logic [NB-1:0]    buf_be,
  input logic [NB*BW-1:0] buf_data,
  input logic [NB*BW-1:0] dout_q,
  input slp_state_e       slp_state
);
  a_r2_buf_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_issue, 2) |-> buf_vld && buf_addr == $past(addr, 2)
                           && buf_be == $past(be, 2) && buf_data == $past(din));

  a_r4_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_vld |=> $stable(buf_vld) && $stable(buf_addr) && $stable(buf_be) && $stable(buf_data));

  a_r5_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_q |=> $stable(dout_q));

  a_r10_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_state != SLP_AWAKE) |-> !wr_issue && !rd_issue);

  a_r10_exit_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_state == SLP_ASLEEP && !sleep) |=> slp_state != SLP_AWAKE);
endmodule

bind lw_sram lw_sram_chk #(.AW(AW), .NB(NB), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .addr(addr), .be(be), .din(din),
  .wr_issue(wr_issue), .rd_issue(rd_issue), .rd_q(rd_q), .pend_vld(pend_vld),
  .buf_vld(buf_vld), .buf_addr(buf_addr), .buf_be(buf_be), .buf_data(buf_data),
  .dout_q(dout_q), .slp_state(slp_state)
);

// File: tb/lw_sram_test.sv
module lw_sram_test;
  localparam int AW = 6, NB = 4, BW = 8, DW = NB * BW;
  localparam int NV = 23;

  typedef struct packed {
    logic          cs;
    logic          we;
    logic [AW-1:0] a;
    logic [NB-1:0] be;
    logic [DW-1:0] d;
    logic          chk;
    logic [DW-1:0] exp;
    logic [7:0]    req;
  } vec_t;

  function automatic vec_t mk(input logic cs, input logic we, input int a, input logic [NB-1:0] be,
                              input logic [DW-1:0] d, input logic chk, input logic [DW-1:0] exp,
                              input int req);
    vec_t v;
    v.cs = cs; v.we = we; v.a = AW'(a); v.be = be; v.d = d;
    v.chk = chk; v.exp = exp; v.req = 8'(req);
    return v;
  endfunction

  // each entry: check dout first (result of read two entries earlier), then drive
  localparam vec_t VEC [NV] = '{
    mk(1,1, 5,4'hF,32'h0,        1,32'h0,       1),  // R1 output zero after reset
    mk(1,1, 9,4'hF,32'h11223344, 0,32'h0,       0),  // R4 back-to-back, data for a5
    mk(1,0, 5,4'h0,32'h55667788, 0,32'h0,       0),  // data for a9, read a5
    mk(1,0, 9,4'h0,32'h0,        0,32'h0,       0),  // R7 read a9 just after its data
    mk(1,1, 5,4'h2,32'h0,        1,32'h11223344,4),  // R4 a5 committed
    mk(1,0, 5,4'h0,32'hAABBCCDD, 1,32'h55667788,7),  // R7 a9 from buffer
    mk(0,0, 0,4'h0,32'h0,        0,32'h0,       0),
    mk(1,0, 9,4'h0,32'h0,        1,32'h1122CC44,6),  // R6 byte1 from buffer
    mk(0,0, 0,4'h0,32'h0,        0,32'h0,       0),
    mk(1,1,20,4'hF,32'h0,        1,32'h55667788,3),  // R3 a9 committed to array
    mk(1,1,20,4'h8,32'hDEADBEEF, 0,32'h0,       0),  // same address back-to-back
    mk(1,0,20,4'h0,32'h99000000, 0,32'h0,       0),
    mk(0,0, 0,4'h0,32'h0,        0,32'h0,       0),
    mk(1,0,33,4'h0,32'h0,        1,32'h99ADBEEF,6),  // R6 byte3 buffer, rest array
    mk(0,0, 0,4'h0,32'h0,        0,32'h0,       0),
    mk(1,1, 7,4'h5,32'h0,        1,32'h0,       1),  // R1 unwritten word is zero
    mk(1,0, 7,4'h0,32'hA1B2C3D4, 0,32'h0,       0),
    mk(0,0, 0,4'h0,32'h0,        0,32'h0,       0),
    mk(1,1, 7,4'hA,32'h0,        1,32'h00B200D4,6),  // R6 bytes 0,2 buffer
    mk(1,0, 7,4'h0,32'hE5F60718, 0,32'h0,       0),
    mk(0,0, 0,4'h0,32'h0,        0,32'h0,       0),
    mk(0,0, 0,4'h0,32'h0,        1,32'hE5B207D4,3),  // R3 partial commit then merge
    mk(0,0, 0,4'h0,32'h0,        1,32'hE5B207D4,5)   // R5 output holds
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, we = 1'b0, oe = 1'b1, sleep = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] be = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lw_sram #(.AW(AW), .NB(NB), .BW(BW), .SLEEP_ENTER(3), .SLEEP_EXIT(3)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .be(be),
    .din(din), .oe(oe), .sleep(sleep), .dout(dout)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic w, input int a, input logic [NB-1:0] b,
                       input logic [DW-1:0] d);
    cs = c; we = w; addr = AW'(a); be = b; din = d;
    @(negedge clk);
  endtask

  task automatic rd(input int a, input logic [DW-1:0] exp, input string tag);
    drive(1, 0, a, '0, '0);
    drive(0, 0, 0, '0, '0);
    check(tag, dout, exp);
  endtask

  task automatic wr(input int a, input logic [NB-1:0] b, input logic [DW-1:0] d);
    drive(1, 1, a, b, '0);
    drive(0, 0, 0, '0, d);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset output", dout, '0);
    rd(0, '0, "R1 reset array");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].chk) check($sformatf("R%0d vector %0d", VEC[i].req, i), dout, VEC[i].exp);
      drive(VEC[i].cs, VEC[i].we, VEC[i].a, VEC[i].be, VEC[i].d);
    end

    // R8 output enable
    oe = 1'b0; #1;
    check("R8 oe low", dout, '0);
    oe = 1'b1; #1;
    check("R8 oe restored", dout, 32'hE5B207D4);

    // R11 write whose data cycle meets sleep rising
    drive(1, 1, 40, 4'hF, '0);
    cs = 1'b0; din = 32'hC0FFEE01; sleep = 1'b1; #1;
    check("R9 sleep output zero", dout, '0);
    @(negedge clk);
    drive(1, 1, 41, 4'hF, '0);              // R10 attempt while asleep
    drive(0, 0, 0, '0, 32'h12345678);
    repeat (5) drive(0, 0, 0, '0, '0);
    sleep = 1'b0;
    drive(0, 0, 0, '0, '0);
    drive(1, 1, 40, 4'hF, '0);              // R10 attempt during exit interval
    drive(0, 0, 0, '0, 32'hFFFFFFFF);
    repeat (5) drive(0, 0, 0, '0, '0);

    rd(40, 32'hC0FFEE01, "R11 pending write kept");
    rd(41, '0, "R10 write ignored");
    rd(5, 32'h1122CC44, "R9 array kept");
    wr(41, 4'hF, 32'h0BADF00D);
    rd(41, 32'h0BADF00D, "R10 accepted after wake");
    rd(9, 32'h55667788, "R2 data sampled on second edge");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule